// File: doc/BRIEF.md
# Two-Wire Bus Short Detector and Sleep Wake Monitor

This block sits beside the receiver of a two-wire differential bus and watches each wire on its own. A wire is dominant when the positive wire is high or the negative wire is low. In the idle state the positive wire is low and the negative wire is high. The block tells apart four kinds of short: either wire stuck at ground or stuck at supply. It then moves reception to the healthy wire so traffic can go on. The bus drivers are not touched and keep driving both wires.

A short that makes the two wires disagree is declared after a brief persistence. A short that holds one wire dominant is declared only after the wire has stayed dominant longer than any legal symbol. Some stuck-dominant shorts first look like a disagreement on the other wire. In that case the long verdict replaces the earlier short one. A declared fault is withdrawn only after the bus has sat cleanly idle for a full inter-frame gap.

While the controller sleeps, a second path looks for bus activity. It raises a wakeup pulse when the bus goes dominant for long enough after having been idle. After a wakeup, a hold output keeps traffic off until the receivers have settled. All time is counted in ticks of a 1 µs strobe.

Top module: `bfm_monitor`

## Requirements
- R1: After reset, all four fault flags, `wake` and `rx_hold` are low, and `rx_path` is 2'b00 (both wires).
- R2: If `bus_p`=0 and `bus_n`=0 are seen on 5 consecutive ticks, `flt_p_gnd` is set. After 4 ticks it is not set.
- R3: If `bus_p`=1 and `bus_n`=1 are seen on 5 consecutive ticks, `flt_n_vdd` is set.
- R4: If `bus_p`=1 is seen on 48 consecutive ticks, `flt_p_vdd` is set and `flt_n_vdd` is cleared. After 47 ticks it is not set. `flt_p_vdd` and `flt_n_vdd` are never high together.
- R5: If `bus_n`=0 is seen on 48 consecutive ticks, `flt_n_gnd` is set and `flt_p_gnd` is cleared. `flt_p_gnd` and `flt_n_gnd` are never high together.
- R6: Any sample that ends the condition restarts its count from zero. This covers a consistent wire pair for the disagreement counts, and the wire leaving dominant for the stuck-dominant counts.
- R7: Set flags stay set until idle (`bus_p`=0, `bus_n`=1) is seen on 96 consecutive ticks. Then all four clear. After 95 ticks they stay set.
- R8: `rx_path` is 2'b10 (negative wire only) when only a positive-wire flag is set. It is 2'b01 (positive wire only) when only a negative-wire flag is set. It is 2'b00 otherwise, and it is never 2'b11.
- R9: With `sleep_req`=1, after idle has been seen, dominant (`bus_p`=1 or `bus_n`=0) on 7 consecutive ticks gives a one-cycle `wake` pulse. Six ticks give none. Nothing is given while `sleep_req`=0.
- R10: A `wake` pulse raises `rx_hold` for 1000 ticks. It is still high after 999 ticks and low after 1000.
- R11: After a wakeup, no further wakeup occurs until idle has been seen again while asleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| bus_p | input | 1 | Positive wire level, high is dominant |
| bus_n | input | 1 | Negative wire level, low is dominant |
| sleep_req | input | 1 | Controller is asleep |
| flt_p_gnd | output | 1 | Positive wire shorted to ground |
| flt_p_vdd | output | 1 | Positive wire shorted to supply |
| flt_n_gnd | output | 1 | Negative wire shorted to ground |
| flt_n_vdd | output | 1 | Negative wire shorted to supply |
| rx_path | output | 2 | Receive source: 00 both, 01 positive only, 10 negative only |
| wake | output | 1 | One-cycle wakeup pulse |
| rx_hold | output | 1 | Traffic inhibit while receivers settle |

## Verification
The assertions assume that `bus_p`, `bus_n` and `sleep_req` are already synchronous to `clk`, and that `tick_us` is high for one cycle at a time. Under that assumption, any rise of a flag can be traced to the wire state sampled one edge before it. The stimulus changes the wires and the sleep input only on falling clock edges. It holds them steady across whole tick counts and issues every tick as a single-cycle strobe. This makes each threshold land on a known edge.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

  // receive source selection
  typedef enum logic [1:0] {
    PATH_DIFF = 2'b00,
    PATH_P    = 2'b01,
    PATH_N    = 2'b10
  } path_e;

  // persistence timer slots
  localparam int IDX_PG   = 0;  // both low: positive wire grounded
  localparam int IDX_NV   = 1;  // both high: negative wire at supply
  localparam int IDX_PV   = 2;  // positive wire dominant too long
  localparam int IDX_NG   = 3;  // negative wire dominant too long
  localparam int IDX_IDLE = 4;  // clean idle for fault release
  localparam int NUM_TMR  = 5;

endpackage

// File: rtl/bfm_persist.sv
// Counts ticks while a condition holds; restarts the moment it lapses.
module bfm_persist #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cond,
  output logic hit
);

  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = LIMIT[W-1:0];

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = tick && (cnt_q != LIM);

  always_comb begin
    cnt_d = cnt_q;
    if (!cond)
      cnt_d = '0;
    else if (cnt_en)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign hit = (cnt_q == LIM);

endmodule

// File: rtl/bfm_wake.sv
// Sleep-time activity detector and post-wakeup settle hold.
module bfm_wake #(
  parameter int WAKE_US   = 7,
  parameter int SETTLE_US = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sleep,
  input  logic idle,
  input  logic dom_any,
  output logic wake,
  output logic hold
);

  localparam int SW = $clog2(SETTLE_US + 1);
  localparam logic [SW-1:0] SETTLE_LD = SETTLE_US[SW-1:0];

  logic          armed_q, armed_d;
  logic          wake_q, wake_d;
  logic [SW-1:0] settle_q, settle_d;
  logic          act_cond, act_hit;

  assign act_cond = sleep && armed_q && dom_any;

  bfm_persist #(.LIMIT(WAKE_US)) u_act (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .cond  (act_cond),
    .hit   (act_hit)
  );

  always_comb begin
    wake_d  = act_hit && armed_q;
    armed_d = armed_q;
    if (!sleep)
      armed_d = 1'b0;
    else if (act_hit)
      armed_d = 1'b0;
    else if (idle)
      armed_d = 1'b1;

    settle_d = settle_q;
    if (wake_q)
      settle_d = SETTLE_LD;
    else if (tick && (settle_q != '0))
      settle_d = settle_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      wake_q   <= 1'b0;
      settle_q <= '0;
    end else begin
      armed_q  <= armed_d;
      wake_q   <= wake_d;
      settle_q <= settle_d;
    end
  end

  assign wake = wake_q;
  assign hold = (settle_q != '0);

endmodule

// File: rtl/bfm_monitor.sv
module bfm_monitor
  import bfm_pkg::*;
#(
  parameter int SHORT_US  = 5,
  parameter int LONG_US   = 48,
  parameter int IDLE_US   = 96,
  parameter int WAKE_US   = 7,
  parameter int SETTLE_US = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       bus_p,
  input  logic       bus_n,
  input  logic       sleep_req,
  output logic       flt_p_gnd,
  output logic       flt_p_vdd,
  output logic       flt_n_gnd,
  output logic       flt_n_vdd,
  output logic [1:0] rx_path,
  output logic       wake,
  output logic       rx_hold
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_i = rst_sync_q[1];

  // persistence conditions per slot
  logic [NUM_TMR-1:0] cond, hit;

  always_comb begin
    cond[IDX_PG]   = !bus_p && !bus_n;
    cond[IDX_NV]   =  bus_p &&  bus_n;
    cond[IDX_PV]   =  bus_p;
    cond[IDX_NG]   = !bus_n;
    cond[IDX_IDLE] = !bus_p &&  bus_n;
  end

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    localparam int LIM = (g == IDX_PG || g == IDX_NV) ? SHORT_US :
                         (g == IDX_IDLE)              ? IDLE_US  : LONG_US;
    bfm_persist #(.LIMIT(LIM)) u_tmr (
      .clk   (clk),
      .rst_n (rst_i),
      .tick  (tick_us),
      .cond  (cond[g]),
      .hit   (hit[g])
    );
  end

  // fault flags
  logic pg_q, pg_d, pv_q, pv_d, ng_q, ng_d, nv_q, nv_d;

  always_comb begin
    pv_d = pv_q;
    if (hit[IDX_IDLE])    pv_d = 1'b0;
    else if (hit[IDX_PV]) pv_d = 1'b1;

    ng_d = ng_q;
    if (hit[IDX_IDLE])    ng_d = 1'b0;
    else if (hit[IDX_NG]) ng_d = 1'b1;

    // a stuck-dominant verdict outranks the mismatch it caused
    nv_d = nv_q;
    if (hit[IDX_IDLE])              nv_d = 1'b0;
    else if (pv_q || hit[IDX_PV])   nv_d = 1'b0;
    else if (hit[IDX_NV])           nv_d = 1'b1;

    pg_d = pg_q;
    if (hit[IDX_IDLE])              pg_d = 1'b0;
    else if (ng_q || hit[IDX_NG])   pg_d = 1'b0;
    else if (hit[IDX_PG])           pg_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pg_q <= 1'b0;
      pv_q <= 1'b0;
      ng_q <= 1'b0;
      nv_q <= 1'b0;
    end else begin
      pg_q <= pg_d;
      pv_q <= pv_d;
      ng_q <= ng_d;
      nv_q <= nv_d;
    end
  end

  // receive source
  logic  p_bad, n_bad;
  path_e path_c;

  assign p_bad = pg_q || pv_q;
  assign n_bad = ng_q || nv_q;

  always_comb begin
    if (p_bad && !n_bad)
      path_c = PATH_N;
    else if (n_bad && !p_bad)
      path_c = PATH_P;
    else
      path_c = PATH_DIFF;
  end

  // sleep wakeup
  bfm_wake #(.WAKE_US(WAKE_US), .SETTLE_US(SETTLE_US)) u_wake (
    .clk     (clk),
    .rst_n   (rst_i),
    .tick    (tick_us),
    .sleep   (sleep_req),
    .idle    (cond[IDX_IDLE]),
    .dom_any (bus_p || !bus_n),
    .wake    (wake),
    .hold    (rx_hold)
  );

  assign flt_p_gnd = pg_q;
  assign flt_p_vdd = pv_q;
  assign flt_n_gnd = ng_q;
  assign flt_n_vdd = nv_q;
  assign rx_path   = path_c;

endmodule

// File: rtl/bfm_monitor_chk.sv
module bfm_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_p,
  input logic       bus_n,
  input logic       sleep_req,
  input logic       flt_p_gnd,
  input logic       flt_p_vdd,
  input logic       flt_n_gnd,
  input logic       flt_n_vdd,
  input logic [1:0] rx_path,
  input logic       wake,
  input logic       rx_hold
);

  AST_PG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_p_gnd) |-> $past(!bus_p && !bus_n));                    // R2
  AST_NV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_n_vdd) |-> $past(bus_p && bus_n));                      // R3
  AST_PV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_p_vdd) |-> $past(bus_p));                               // R4
  AST_NG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_n_gnd) |-> $past(!bus_n));                              // R5
  AST_VDD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(flt_p_vdd && flt_n_vdd));                                       // R4
  AST_GND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(flt_p_gnd && flt_n_gnd));                                       // R5
  AST_PV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flt_p_vdd) |-> $past(!bus_p && bus_n));                     // R7
  AST_NG_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flt_n_gnd) |-> $past(!bus_p && bus_n));                     // R7
  AST_PATH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_path != 2'b11);                                                // R8
  AST_WAKE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(sleep_req, 2));                                    // R9
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);                                                  // R9
  AST_HOLD_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> rx_hold);                                                // R10

endmodule

bind bfm_monitor bfm_monitor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_p     (bus_p),
  .bus_n     (bus_n),
  .sleep_req (sleep_req),
  .flt_p_gnd (flt_p_gnd),
  .flt_p_vdd (flt_p_vdd),
  .flt_n_gnd (flt_n_gnd),
  .flt_n_vdd (flt_n_vdd),
  .rx_path   (rx_path),
  .wake      (wake),
  .rx_hold   (rx_hold)
);

// File: tb/sim_bfm_monitor.sv
`timescale 1ns/1ps
module sim_bfm_monitor;

  logic       clk = 1'b0;
  logic       rst_n, tick_us, bus_p, bus_n, sleep_req;
  logic       flt_p_gnd, flt_p_vdd, flt_n_gnd, flt_n_vdd, wake, rx_hold;
  logic [1:0] rx_path;

  int n_chk = 0;
  int n_bad = 0;
  int wake_seen = 0;

  always #2.5 clk = ~clk;

  bfm_monitor u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .bus_p(bus_p), .bus_n(bus_n),
    .sleep_req(sleep_req), .flt_p_gnd(flt_p_gnd), .flt_p_vdd(flt_p_vdd),
    .flt_n_gnd(flt_n_gnd), .flt_n_vdd(flt_n_vdd), .rx_path(rx_path),
    .wake(wake), .rx_hold(rx_hold)
  );

  always @(negedge clk) if (wake === 1'b1) wake_seen++;

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // k microsecond ticks, each a one-cycle strobe followed by idle cycles
  task automatic step(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk) tick_us = 1'b1;
      @(negedge clk) tick_us = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  // {req, p, n, ticks, {pg,pv,ng,nv}, path}
  localparam int NV = 24;
  localparam logic [19:0] VEC [NV] = '{
    {4'd1, 1'b0, 1'b1, 8'd10, 4'b0000, 2'b00},  // R1 idle, nothing flagged
    {4'd2, 1'b0, 1'b0, 8'd4,  4'b0000, 2'b00},  // R2 one short of threshold
    {4'd2, 1'b0, 1'b0, 8'd1,  4'b1000, 2'b10},  // R2 threshold reached
    {4'd7, 1'b0, 1'b1, 8'd95, 4'b1000, 2'b10},  // R7 idle one short
    {4'd7, 1'b0, 1'b1, 8'd1,  4'b0000, 2'b00},  // R7 released
    {4'd3, 1'b1, 1'b1, 8'd5,  4'b0001, 2'b01},  // R3
    {4'd4, 1'b1, 1'b0, 8'd42, 4'b0001, 2'b01},  // R4 positive high 47
    {4'd4, 1'b1, 1'b0, 8'd1,  4'b0100, 2'b10},  // R4 48, reclassified
    {4'd7, 1'b0, 1'b1, 8'd96, 4'b0000, 2'b00},  // R7
    {4'd2, 1'b0, 1'b0, 8'd5,  4'b1000, 2'b10},  // R2
    {4'd5, 1'b0, 1'b0, 8'd43, 4'b0010, 2'b01},  // R5 negative low 48
    {4'd7, 1'b0, 1'b1, 8'd96, 4'b0000, 2'b00},  // R7
    {4'd6, 1'b1, 1'b1, 8'd4,  4'b0000, 2'b00},  // R6
    {4'd6, 1'b1, 1'b0, 8'd1,  4'b0000, 2'b00},  // R6 consistent sample
    {4'd6, 1'b1, 1'b1, 8'd4,  4'b0000, 2'b00},  // R6 count restarted
    {4'd6, 1'b0, 1'b1, 8'd96, 4'b0000, 2'b00},  // R6
    {4'd8, 1'b0, 1'b0, 8'd5,  4'b1000, 2'b10},  // R8 positive faulty
    {4'd8, 1'b0, 1'b1, 8'd1,  4'b1000, 2'b10},  // R8
    {4'd8, 1'b1, 1'b1, 8'd5,  4'b1001, 2'b00},  // R8 both faulty
    {4'd7, 1'b0, 1'b1, 8'd96, 4'b0000, 2'b00},  // R7
    {4'd6, 1'b1, 1'b0, 8'd47, 4'b0000, 2'b00},  // R6 long counts 47
    {4'd6, 1'b0, 1'b1, 8'd1,  4'b0000, 2'b00},  // R6 leave dominant
    {4'd6, 1'b1, 1'b0, 8'd47, 4'b0000, 2'b00},  // R6 restarted
    {4'd6, 1'b0, 1'b1, 8'd96, 4'b0000, 2'b00}   // R6
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_us = 1'b0; bus_p = 1'b0; bus_n = 1'b1; sleep_req = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", "flags", {12'd0, flt_p_gnd, flt_p_vdd, flt_n_gnd, flt_n_vdd}, 16'h0);
    check("R1", "path", {14'd0, rx_path}, 16'h0);
    check("R1", "wake/hold", {14'd0, wake, rx_hold}, 16'h0);

    for (int v = 0; v < NV; v++) begin
      bus_p = VEC[v][15];
      bus_n = VEC[v][14];
      step(int'(VEC[v][13:6]));
      check($sformatf("R%0d", VEC[v][19:16]), $sformatf("vector %0d flags", v),
            {12'd0, flt_p_gnd, flt_p_vdd, flt_n_gnd, flt_n_vdd}, {12'd0, VEC[v][5:2]});
      check($sformatf("R%0d", VEC[v][19:16]), $sformatf("vector %0d path", v),
            {14'd0, rx_path}, {14'd0, VEC[v][1:0]});
    end

    // R9 awake: dominant activity gives no wakeup
    bus_p = 1'b1; bus_n = 1'b0; step(10);
    bus_p = 1'b0; bus_n = 1'b1; step(1);
    check("R9", "wake while awake", 16'(wake_seen), 16'd0);

    // R9 asleep: 6 ticks too short, 7 ticks wake
    sleep_req = 1'b1;
    step(2);
    bus_p = 1'b1; bus_n = 1'b0; step(6);
    check("R9", "wake after 6", 16'(wake_seen), 16'd0);
    bus_p = 1'b0; bus_n = 1'b1; step(1);
    bus_p = 1'b1; bus_n = 1'b0; step(7);
    check("R9", "wake after 7", 16'(wake_seen), 16'd1);
    check("R10", "hold after wake", {15'd0, rx_hold}, 16'd1);

    // R11 no rearm without idle
    step(20);
    check("R11", "no second wake", 16'(wake_seen), 16'd1);
    bus_p = 1'b0; bus_n = 1'b1; step(1);
    bus_p = 1'b1; bus_n = 1'b0; step(7);
    check("R11", "wake after rearm", 16'(wake_seen), 16'd2);

    // R10 settle window length
    sleep_req = 1'b0;
    bus_p = 1'b0; bus_n = 1'b1;
    step(999);
    check("R10", "hold at 999", {15'd0, rx_hold}, 16'd1);
    step(1);
    check("R10", "hold at 1000", {15'd0, rx_hold}, 16'd0);
    check("R1", "flags after wake tests", {12'd0, flt_p_gnd, flt_p_vdd, flt_n_gnd, flt_n_vdd}, 16'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule